// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device side of a parallel ATA register interface with two devices on one cable. The host writes and reads bytes through a 3-bit register address. It also has a separate device-control write and an alternate-status output. Every task-file write lands in both devices, because both devices see the same bus. The feature, sector-count and three LBA registers each keep a previous-value copy, which 48-bit addressing needs. The host reads those copies back by setting the high-order select bit in device control.

The block tracks which device is active and holds the interrupt line. It also runs the soft-reset sequence started from the device-control register. It does not decode commands. A command write only drops the interrupt and passes the command byte to an external executor with a one-cycle strobe. The executor in turn raises `exec_irq` when it wants to interrupt the host.

Register addresses: 0 data (reads 0xFF, writes ignored), 1 feature on write and error on read, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device/head, 7 command on write and status on read. Device-control bits: bit 7 high-order readback select, bit 2 soft reset, bit 1 interrupt disable. Status bits: BUSY 0x80, READY 0x40, SEEK 0x10. Parameter `PACKET_MASK` marks which devices are packet-type devices (bit d for device d; the default makes device 1 a packet device). Parameter `RST_CYCLES` sets how long soft reset takes.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After `rst_n` is released, the registers hold these values:

  | Item | Value after reset |
  |------|-------------------|
  | Status of a disk device | 0x50 |
  | Status of a packet device | 0x00 |
  | Error | 0x01 |
  | Sector count (address 2) | 0x01 |
  | LBA low (address 3) | 0x01 |
  | LBA mid and LBA high (addresses 4, 5) | 0x00 |
  | Device/head (address 6) | 0xA0 |
  | All previous-value copies | 0x00 |
  | Active device | 0 |
  | Device control | 0x00 |
  | `intrq` | low |
  | Data port (address 0) reads | 0xFF |

- R2: Task-file writes go to both devices. After the active device changes, the host reads back the same values for addresses 2 to 6.
- R3: A write to address 1, 2, 3, 4 or 5 first copies the register's current value into its previous-value copy, then stores the new byte.
- R4: While device-control bit 7 is 1, reads of addresses 2 to 5 return the previous-value copies. While it is 0, they return the current values. Address 1 always reads the error register.
- R5: A write to address 1, 6 or 7 clears device-control bit 7. Writes to addresses 2 to 5 leave it unchanged.
- R6: A device/head write stores the byte ORed with 0xA0. Bit 4 of the written byte selects the active device. Status (address 7), error (address 1) and `alt_status` return the active device's registers.
- R7: A command write (address 7) makes `cmd_strobe` high for exactly one cycle, starting on the next cycle, with `cmd_code` equal to the written byte. It also clears any pending interrupt, so `intrq` is low in that cycle.
- R8: `intrq` is the pending-interrupt flag ANDed with the inverse of device-control bit 1. `exec_irq` sets the flag. A status read at address 7 clears it. Reading `alt_status` leaves it unchanged.
- R9: When a device-control write takes bit 2 from 1 to 0, both devices show BUSY (bit 7) in status on the next cycle. A write that takes bit 2 from 0 to 1, or leaves it unchanged, does not start a reset.
- R10: A soft reset completes `RST_CYCLES` cycles after the BUSY cycle begins. On completion, each of the following takes its R1 value:
  - device/head
  - sector count, LBA low, LBA mid and LBA high
  - the previous-value copies
  - each device's status
  - the error register

  The active device stays as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tf_wr | input | 1 | Task-file write strobe |
| tf_rd | input | 1 | Task-file read strobe (only address 7 has a read side effect) |
| tf_addr | input | 3 | Task-file register address |
| tf_wdata | input | 8 | Task-file write data |
| tf_rdata | output | 8 | Task-file read data, combinational from `tf_addr` |
| ctl_wr | input | 1 | Device-control write strobe |
| ctl_wdata | input | 8 | Device-control write data |
| alt_status | output | 8 | Active device status, read without side effects |
| exec_irq | input | 1 | Executor interrupt request |
| intrq | output | 1 | Interrupt line to the host |
| cmd_strobe | output | 1 | One-cycle command issue pulse |
| cmd_code | output | 8 | Command byte that goes with `cmd_strobe` |

## Verification
The bench drives long random mixes of the following, and compares every readable register against a model of the shared task file:
- shadowed-register writes
- device/head writes
- device-control writes that toggle high-order readback and interrupt disable

A design that moved the new byte rather than the old one into the copy would show up in that comparison. So would one that cleared the readback select on every write, or kept per-device copies that drift apart.

Directed cases cover the following corner cases:
- The soft-reset edge. A design that fires on the rising edge would show BUSY too early.
- The exact completion cycle. An off-by-one counter would leave BUSY set or clear it early.
- The per-kind reset status.
- The interrupt drop on a command write.
- The alternate-status read. A design that cleared the interrupt on it would lose a pending interrupt.

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter int         RST_CYCLES  = 4,
  parameter logic [1:0] PACKET_MASK = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tf_wr,
  input  logic       tf_rd,
  input  logic [2:0] tf_addr,
  input  logic [7:0] tf_wdata,
  output logic [7:0] tf_rdata,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] alt_status,
  input  logic       exec_irq,
  output logic       intrq,
  output logic       cmd_strobe,
  output logic [7:0] cmd_code
);

  localparam int         CW       = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [7:0] DH_FIXED = 8'hA0;
  localparam logic [7:0] ST_DISK  = 8'h50;
  localparam logic [7:0] ST_BUSY  = 8'h80;

  logic [7:0]    cur_q [1:5];
  logic [7:0]    prev_q [1:5];
  logic [7:0]    dh_q;
  logic          unit_q;
  logic [7:0]    ctl_q;
  logic [7:0]    stat_q [2];
  logic [7:0]    err_q [2];
  logic          irq_pend_q;
  logic          strobe_q;
  logic [7:0]    code_q;
  logic          srst_pend_q;
  logic [CW-1:0] srst_cnt_q;

  wire srst_fall = ctl_wr && ctl_q[2] && !ctl_wdata[2];
  wire srst_done = srst_pend_q && (srst_cnt_q == CW'(RST_CYCLES - 1)) && !srst_fall;
  wire tf_shadow = tf_addr >= 3'd1 && tf_addr <= 3'd5;
  wire hob_kill  = tf_wr && (tf_addr == 3'd1 || tf_addr == 3'd6 || tf_addr == 3'd7);

  function automatic logic [7:0] sig_val(int r);
    return (r == 2 || r == 3) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] kind_stat(int d);
    return PACKET_MASK[d] ? 8'h00 : ST_DISK;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 1; r <= 5; r++) begin
        cur_q[r]  <= sig_val(r);
        prev_q[r] <= 8'h00;
      end
      for (int d = 0; d < 2; d++) begin
        stat_q[d] <= kind_stat(d);
        err_q[d]  <= 8'h01;
      end
      dh_q        <= DH_FIXED;
      unit_q      <= 1'b0;
      ctl_q       <= 8'h00;
      irq_pend_q  <= 1'b0;
      strobe_q    <= 1'b0;
      code_q      <= 8'h00;
      srst_pend_q <= 1'b0;
      srst_cnt_q  <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (exec_irq) irq_pend_q <= 1'b1;
      if (tf_rd && tf_addr == 3'd7) irq_pend_q <= 1'b0;
      if (tf_wr) begin
        if (tf_shadow) begin
          prev_q[tf_addr] <= cur_q[tf_addr];
          cur_q[tf_addr]  <= tf_wdata;
        end else if (tf_addr == 3'd6) begin
          dh_q   <= tf_wdata | DH_FIXED;
          unit_q <= tf_wdata[4];
        end else if (tf_addr == 3'd7) begin
          irq_pend_q <= 1'b0;
          strobe_q   <= 1'b1;
          code_q     <= tf_wdata;
        end
      end
      if (hob_kill) ctl_q[7] <= 1'b0;
      if (ctl_wr) ctl_q <= ctl_wdata;
      if (srst_fall) begin
        for (int d = 0; d < 2; d++) stat_q[d] <= stat_q[d] | ST_BUSY;
        srst_pend_q <= 1'b1;
        srst_cnt_q  <= '0;
      end else if (srst_done) begin
        for (int r = 1; r <= 5; r++) begin
          cur_q[r]  <= sig_val(r);
          prev_q[r] <= 8'h00;
        end
        for (int d = 0; d < 2; d++) begin
          stat_q[d] <= kind_stat(d);
          err_q[d]  <= 8'h01;
        end
        dh_q        <= DH_FIXED;
        srst_pend_q <= 1'b0;
      end else if (srst_pend_q) begin
        srst_cnt_q <= srst_cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (tf_addr)
      3'd0:    tf_rdata = 8'hFF;
      3'd1:    tf_rdata = err_q[unit_q];
      3'd6:    tf_rdata = dh_q;
      3'd7:    tf_rdata = stat_q[unit_q];
      default: tf_rdata = ctl_q[7] ? prev_q[tf_addr] : cur_q[tf_addr];
    endcase
  end

  assign alt_status = stat_q[unit_q];
  assign intrq      = irq_pend_q & ~ctl_q[1];
  assign cmd_strobe = strobe_q;
  assign cmd_code   = code_q;

  a_r3_shift_copy: assert property (@(posedge clk) disable iff (!rst_n)
    tf_wr && tf_addr == 3'd2 && !srst_pend_q |=> prev_q[2] == $past(cur_q[2]));

  a_r5_hob_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hob_kill && !ctl_wr |=> !ctl_q[7]);

  a_r7_cmd_issue: assert property (@(posedge clk) disable iff (!rst_n)
    tf_wr && tf_addr == 3'd7 |=> cmd_strobe && !intrq && cmd_code == $past(tf_wdata));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[1] |=> !intrq);

  a_r9_busy_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fall |=> stat_q[0][7] && stat_q[1][7]);

  a_r10_reset_done: assert property (@(posedge clk) disable iff (!rst_n)
    srst_done |=> !srst_pend_q && dh_q == DH_FIXED && prev_q[5] == 8'h00);

endmodule

// File: tb/test_ata_taskfile_regs.sv
module test_ata_taskfile_regs;
  localparam int RST_CYCLES = 4;

  logic       clk = 0, rst_n = 0;
  logic       tf_wr = 0, tf_rd = 0, ctl_wr = 0, exec_irq = 0;
  logic [2:0] tf_addr = 0;
  logic [7:0] tf_wdata = 0, ctl_wdata = 0;
  logic [7:0] tf_rdata, alt_status, cmd_code;
  logic       intrq, cmd_strobe;

  ata_taskfile_regs #(.RST_CYCLES(RST_CYCLES), .PACKET_MASK(2'b10)) i_ata_taskfile_regs (
    .clk(clk), .rst_n(rst_n), .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_addr(tf_addr),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .alt_status(alt_status), .exec_irq(exec_irq), .intrq(intrq),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] m_cur [1:5];
  logic [7:0] m_prev [1:5];
  logic [7:0] m_dh;
  logic       m_hob, m_unit;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_stat(logic u);
    return u ? 8'h00 : 8'h50;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    case (a)
      0: return 8'hFF;
      1: return 8'h01;
      6: return m_dh;
      7: return m_stat(m_unit);
      default: return m_hob ? m_prev[a] : m_cur[a];
    endcase
  endfunction

  task automatic model_reset();
    for (int r = 1; r <= 5; r++) begin
      m_cur[r]  = (r == 2 || r == 3) ? 8'h01 : 8'h00;
      m_prev[r] = 8'h00;
    end
    m_dh = 8'hA0;
  endtask

  task automatic tf_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    tf_wr = 1; tf_addr = a; tf_wdata = d;
    @(negedge clk);
    tf_wr = 0;
    if (a >= 1 && a <= 5) begin m_prev[a] = m_cur[a]; m_cur[a] = d; end
    if (a == 6) begin m_dh = d | 8'hA0; m_unit = d[4]; end
    if (a == 1 || a == 6 || a == 7) m_hob = 0;
  endtask

  task automatic ctl_write(logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 0;
    m_hob = d[7];
  endtask

  task automatic read_at(logic [2:0] a, string req);
    tf_addr = a;
    #1;
    chk(req, tf_rdata, exp_rd(a));
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset(); m_hob = 0; m_unit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) read_at(3'(a), "R1");
    chk("R1 intrq", {7'd0, intrq}, 8'h00);
    chk("R1 alt_status", alt_status, 8'h50);

    // R3/R4 directed: two writes to count, read both copies
    tf_write(3'd2, 8'h11);
    tf_write(3'd2, 8'h22);
    read_at(3'd2, "R3 current");
    ctl_write(8'h80);
    read_at(3'd2, "R4 previous");
    read_at(3'd1, "R4 error unshadowed");
    // R5: count write keeps HOB, feature write clears it
    tf_write(3'd3, 8'h33);
    read_at(3'd3, "R5 hob kept");
    tf_write(3'd1, 8'h44);
    read_at(3'd2, "R5 hob cleared");

    // R6/R2: select device 1 (packet)
    tf_write(3'd6, 8'h1F);
    read_at(3'd6, "R6 devhead");
    chk("R6 alt_status dev1", alt_status, 8'h00);
    read_at(3'd7, "R6 status dev1");
    for (int a = 2; a <= 5; a++) read_at(3'(a), "R2 shared");
    tf_write(3'd6, 8'h40);
    chk("R6 alt_status dev0", alt_status, 8'h50);

    // Random mix, R2 R3 R4 R5 R6
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op <= 5) tf_write(3'(op + 1), 8'($urandom));
      else if (op == 6) ctl_write({1'($urandom), 5'd0, 1'($urandom), 1'b0});
      else read_at(3'($urandom_range(0, 7)), "R4 random read");
    end
    ctl_write(8'h00);
    m_hob = 0;

    // R8: interrupt, alt status has no side effect, mask, status read clears
    @(negedge clk); exec_irq = 1; @(negedge clk); exec_irq = 0;
    chk("R8 intrq set", {7'd0, intrq}, 8'h01);
    tf_addr = 3'd0; #1; chk("R8 alt read", {7'd0, intrq}, 8'h01);
    ctl_write(8'h02);
    chk("R8 masked", {7'd0, intrq}, 8'h00);
    ctl_write(8'h00);
    chk("R8 unmasked", {7'd0, intrq}, 8'h01);
    @(negedge clk); tf_rd = 1; tf_addr = 3'd7; @(negedge clk); tf_rd = 0;
    chk("R8 status read clears", {7'd0, intrq}, 8'h00);

    // R7: command write drops interrupt and strobes once
    @(negedge clk); exec_irq = 1; @(negedge clk); exec_irq = 0;
    tf_write(3'd7, 8'hEC);
    chk("R7 strobe", {7'd0, cmd_strobe}, 8'h01);
    chk("R7 code", cmd_code, 8'hEC);
    chk("R7 intrq low", {7'd0, intrq}, 8'h00);
    @(negedge clk);
    chk("R7 strobe one cycle", {7'd0, cmd_strobe}, 8'h00);

    // R9: rising and steady writes do not reset
    tf_write(3'd6, 8'h10);
    tf_write(3'd4, 8'h77);
    ctl_write(8'h04);
    chk("R9 rise no busy", alt_status, 8'h00);
    ctl_write(8'h04);
    chk("R9 steady no busy", alt_status, 8'h00);
    ctl_write(8'h00);
    chk("R9 fall busy dev1", alt_status, 8'h80);
    tf_addr = 3'd7; #1;
    chk("R9 fall busy read", tf_rdata, 8'h80);
    repeat (RST_CYCLES - 1) @(negedge clk);
    chk("R10 still busy", alt_status, 8'h80);
    @(negedge clk);
    model_reset();
    chk("R10 packet status", alt_status, 8'h00);
    for (int a = 2; a <= 6; a++) read_at(3'(a), "R10 signature");
    ctl_write(8'h80);
    for (int a = 2; a <= 5; a++) read_at(3'(a), "R10 copies cleared");
    ctl_write(8'h00);
    tf_write(3'd6, 8'h00);
    chk("R10 disk status", alt_status, 8'h50);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule